// File: doc/BRIEF.md
# Serial Sampling Interface with Power-Mode Control

This block models the digital side of a sampling converter's serial port. A host drives an active-low chip select and a serial clock, both asynchronous to the block's system clock. Inside, both are brought through synchronizers, and their edges are detected in the system clock domain. The falling edge of chip select opens a frame. At that point a 12-bit sample word is captured from a parallel input, the sample circuit is switched to hold, and the serial data driver is enabled. The word then leaves MSB first, behind a run of leading zeros, with one bit advancing on each serial clock falling edge.

The same pins control power. When chip select rises, the block looks at how many serial clock falling edges the frame has seen, and that number sets the next power mode. Low counts are treated as glitches and ignored. A count in the middle band puts the block to sleep. A long frame keeps the block awake, or wakes it up. A power-up timer, counted in system clocks, marks the frames that follow a wake-up as carrying invalid data until it expires. A parameter selects whether reset leaves the block awake or asleep.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset with the default parameters, the data driver is disabled, the block is awake, the sample circuit is tracking (track_out=1) and data_invalid is 0.
- R2: A chip-select falling edge enables the data driver and drives a 0 on the data line. When the block is awake, it also switches track_out to 0 (hold).
- R3: The frame word is 4 leading zeros followed by the 12-bit sample, MSB first. The data line shows bit 15 of the frame word at the chip-select fall, and bit 15-k after the k-th serial clock falling edge.
- R4: On the 16th serial clock falling edge of a frame, the data driver is disabled. The falling-edge count saturates at 16.
- R5: In an awake frame, track_out stays 0 through the 13th falling edge and returns to 1 on the next serial clock rising edge.
- R6: A chip-select rise before the 16th falling edge ends the frame and disables the data driver at once.
- R7: When awake, a chip-select rise after fewer than 2 falling edges leaves the block awake.
- R8: When awake, a chip-select rise after 2 to 9 falling edges puts the block into power-down: powered_out goes to 0 and track_out goes to 0.
- R9: When awake, a chip-select rise after 10 or more falling edges leaves the block awake and tracking.
- R10: When asleep, a frame whose chip select rises before the 10th falling edge returns the block to power-down.
- R11: When asleep, a frame that keeps chip select low through 10 or more falling edges wakes the block: powered_out goes to 1.
- R12: In a wake-up frame, track_out returns to 1 on the first serial clock edge of either polarity after the chip-select fall.
- R13: data_invalid is set at a chip-select fall if the block is asleep or the power-up timer is still running, is cleared at a fall otherwise, and holds its value between falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous chip select, active low |
| sclk_in | input | 1 | Asynchronous serial clock |
| sample_in | input | 12 | Sample word, captured at the chip-select fall |
| sdata_out | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Data driver enable (0 = three-state) |
| track_out | output | 1 | 1 = sample circuit tracking, 0 = holding |
| powered_out | output | 1 | 1 = awake, 0 = asleep or waking |
| data_invalid | output | 1 | Current frame's data is not a valid sample |

## Verification
The assertions assume a few things about the inputs. Chip select and serial clock each stay at one level for several system clocks, so every pin change produces exactly one detected edge. A chip-select edge never lands in the same synchronized cycle as a serial clock edge. Without that spacing, the count used for the mode decision would be ambiguous by one. The stimulus meets these assumptions by keeping each serial clock phase four system clocks long and by leaving a full phase between the last serial clock edge and any chip-select change. It also exercises the count boundaries 0, 1, 2, 9, 10 and 16 directly.

// File: rtl/sadc_pkg.sv
// Shared types for the serial sampling interface.
// Assumes: nothing beyond IEEE 1800-2017.
package sadc_pkg;
    // Power mode of the converter model.
    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_DOWN   = 2'd1,
        PM_WAKING = 2'd2
    } pmode_t;
endpackage

// File: rtl/sadc_edge_sync.sv
// Synchronizes asynchronous inputs into clk and flags their edges.
// Assumes: STAGES >= 2; each input is stable for more than one clk period.
module sadc_edge_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] pipe;
        logic              prev;

        // Shift the input through the synchronizer and keep the previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= {STAGES{IDLE[i]}};
                prev <= IDLE[i];
            end else begin
                pipe <= {pipe[STAGES-2:0], din[i]};
                prev <= pipe[STAGES-1];
            end
        end

        // Level and single-cycle edge pulses.
        always_comb begin
            level[i] = pipe[STAGES-1];
            rise[i]  = pipe[STAGES-1] & ~prev;
            fall[i]  = ~pipe[STAGES-1] & prev;
        end
    end
endmodule

// File: rtl/sadc_frame_shift.sv
// Frame counter and output shifter: captures the sample at the chip-select fall
// and shifts the frame word MSB first on each serial clock fall.
// Assumes: edge pulses are single-cycle and chip-select edges never coincide.
module sadc_frame_shift #(
    parameter int SAMPLE_W = 12,
    parameter int LEAD_ZEROS = 4,
    localparam int FRAME_LEN = SAMPLE_W + LEAD_ZEROS,
    localparam int CW = $clog2(FRAME_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_low,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                sclk_fall,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [CW-1:0]       edge_cnt,
    output logic                sdata,
    output logic                oe
);
    localparam logic [CW-1:0] CNT_MAX = CW'(FRAME_LEN);

    logic [FRAME_LEN-1:0] shreg;
    logic                 active;

    // Count serial clock falls while chip select is low, saturating at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (cs_fall) begin
            edge_cnt <= '0;
        end else if (sclk_fall && cs_low && edge_cnt != CNT_MAX) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // Load, shift and terminate the outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            active <= 1'b0;
        end else if (cs_fall) begin
            shreg  <= {{LEAD_ZEROS{1'b0}}, sample};
            active <= 1'b1;
        end else if (cs_rise) begin
            active <= 1'b0;
        end else if (sclk_fall && active) begin
            shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
            if (edge_cnt == CNT_MAX - 1'b1) begin
                active <= 1'b0;
            end
        end
    end

    // Drive the data pin only while a frame is active.
    always_comb begin
        oe    = active;
        sdata = active & shreg[FRAME_LEN-1];
    end
endmodule

// File: rtl/sadc_power_fsm.sv
// Power-mode state machine, track/hold control, power-up timer and data-valid flag.
// Assumes: edge_cnt is the fall count of the current frame, sampled at cs_rise.
module sadc_power_fsm
    import sadc_pkg::*;
#(
    parameter int CW = 5,
    parameter int DOWN_MIN = 2,
    parameter int KEEP_MIN = 10,
    parameter int HOLD_EDGES = 13,
    parameter int PWRUP_CYCLES = 100,
    parameter bit RESET_DOWN = 1'b0,
    localparam int TW = $clog2(PWRUP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sclk_fall,
    input  logic          sclk_rise,
    input  logic [CW-1:0] edge_cnt,
    output logic          track,
    output logic          powered,
    output logic          invalid
);
    localparam logic [CW-1:0] C_DOWN = CW'(DOWN_MIN);
    localparam logic [CW-1:0] C_KEEP = CW'(KEEP_MIN);
    localparam logic [CW-1:0] C_HOLD = CW'(HOLD_EDGES);
    localparam logic [TW-1:0] T_LOAD = TW'(PWRUP_CYCLES);

    pmode_t        state;
    logic [TW-1:0] timer;
    logic          first_pend;

    // Mode transitions, track/hold and timer, all keyed on synchronized edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RESET_DOWN ? PM_DOWN : PM_NORMAL;
            timer      <= '0;
            track      <= ~RESET_DOWN;
            first_pend <= 1'b0;
            invalid    <= 1'b0;
        end else begin
            if (timer != '0) begin
                timer <= timer - 1'b1;
            end
            if (cs_fall) begin
                invalid <= (state != PM_NORMAL) || (timer != '0);
                track   <= 1'b0;
                if (state == PM_DOWN) begin
                    state      <= PM_WAKING;
                    timer      <= T_LOAD;
                    first_pend <= 1'b1;
                end else begin
                    first_pend <= 1'b0;
                end
            end else if (cs_rise) begin
                first_pend <= 1'b0;
                unique case (state)
                    PM_NORMAL: begin
                        if (edge_cnt >= C_DOWN && edge_cnt < C_KEEP) begin
                            state <= PM_DOWN;
                            track <= 1'b0;
                            timer <= '0;
                        end else begin
                            track <= 1'b1;
                        end
                    end
                    PM_WAKING: begin
                        if (edge_cnt >= C_KEEP) begin
                            state <= PM_NORMAL;
                            track <= 1'b1;
                        end else begin
                            state <= PM_DOWN;
                            track <= 1'b0;
                            timer <= '0;
                        end
                    end
                    default: begin
                        state <= state;
                    end
                endcase
            end else if (first_pend && (sclk_rise || sclk_fall)) begin
                track      <= 1'b1;
                first_pend <= 1'b0;
            end else if (state == PM_NORMAL && edge_cnt >= C_HOLD && sclk_rise) begin
                track <= 1'b1;
            end
        end
    end

    // Only the fully awake state reports as powered.
    always_comb begin
        powered = (state == PM_NORMAL);
    end
endmodule

// File: rtl/sadc_serial_if.sv
// Top of the serial sampling interface: synchronizes chip select and serial clock,
// shifts the sample out and runs the power-mode decision.
// Assumes: host pin levels each last several clk periods.
module sadc_serial_if #(
    parameter int SAMPLE_W = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DOWN_MIN = 2,
    parameter int KEEP_MIN = 10,
    parameter int HOLD_EDGES = 13,
    parameter int PWRUP_CYCLES = 100,
    parameter bit RESET_DOWN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_in,
    input  logic                sclk_in,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                sdata_out,
    output logic                sdata_oe,
    output logic                track_out,
    output logic                powered_out,
    output logic                data_invalid
);
    localparam int FRAME_LEN = SAMPLE_W + LEAD_ZEROS;
    localparam int CW = $clog2(FRAME_LEN + 1);

    logic [1:0]    lvl, rise, fall;
    logic          cs_fall, cs_rise, cs_low, sclk_fall, sclk_rise;
    logic [CW-1:0] edge_cnt;

    sadc_edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sclk_in, cs_n_in}),
        .level(lvl), .rise(rise), .fall(fall)
    );

    // Name the individual edge strobes.
    always_comb begin
        cs_low    = ~lvl[0];
        cs_fall   = fall[0];
        cs_rise   = rise[0];
        sclk_fall = fall[1];
        sclk_rise = rise[1];
    end

    sadc_frame_shift #(.SAMPLE_W(SAMPLE_W), .LEAD_ZEROS(LEAD_ZEROS)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .sclk_fall(sclk_fall), .sample(sample_in),
        .edge_cnt(edge_cnt), .sdata(sdata_out), .oe(sdata_oe)
    );

    sadc_power_fsm #(
        .CW(CW), .DOWN_MIN(DOWN_MIN), .KEEP_MIN(KEEP_MIN), .HOLD_EDGES(HOLD_EDGES),
        .PWRUP_CYCLES(PWRUP_CYCLES), .RESET_DOWN(RESET_DOWN)
    ) u_pm (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .edge_cnt(edge_cnt),
        .track(track_out), .powered(powered_out), .invalid(data_invalid)
    );
endmodule

// File: rtl/sadc_serial_if_chk.sv
// Protocol checker for sadc_serial_if, attached by bind.
// Assumes: chip-select edges never share a cycle with serial clock edges.
module sadc_serial_if_chk #(
    parameter int CW = 5,
    parameter int FRAME_LEN = 16,
    parameter int DOWN_MIN = 2,
    parameter int KEEP_MIN = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_fall,
    input logic          cs_rise,
    input logic          sclk_fall,
    input logic [CW-1:0] edge_cnt,
    input logic          sdata_out,
    input logic          sdata_oe,
    input logic          track_out,
    input logic          powered_out,
    input logic          data_invalid
);
    p_open_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (sdata_oe && !sdata_out && !track_out));

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdata_oe);

    p_end_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !cs_rise && !cs_fall && sdata_oe && edge_cnt == CW'(FRAME_LEN - 1)) |=> !sdata_oe);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= CW'(FRAME_LEN));

    p_enter_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && powered_out && edge_cnt >= CW'(DOWN_MIN) && edge_cnt < CW'(KEEP_MIN))
        |=> (!powered_out && !track_out));

    p_stay_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && powered_out && (edge_cnt < CW'(DOWN_MIN) || edge_cnt >= CW'(KEEP_MIN)))
        |=> (powered_out && track_out));

    p_invalid_asleep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !powered_out) |=> data_invalid);

    p_invalid_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(data_invalid));
endmodule

bind sadc_serial_if sadc_serial_if_chk #(
    .CW(CW), .FRAME_LEN(FRAME_LEN), .DOWN_MIN(DOWN_MIN), .KEEP_MIN(KEEP_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .edge_cnt(edge_cnt), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .track_out(track_out), .powered_out(powered_out),
    .data_invalid(data_invalid)
);

// File: tb/sim_sadc_serial_if.sv
// Directed bench for sadc_serial_if.
module sim_sadc_serial_if;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 4;          // system clocks per serial clock phase
    localparam int PWRUP = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample = '0;
    logic        sdata, oe, track, powered, inval;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sadc_serial_if #(.PWRUP_CYCLES(PWRUP)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk),
        .sample_in(sample), .sdata_out(sdata), .sdata_oe(oe),
        .track_out(track), .powered_out(powered), .data_invalid(inval)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One frame of nf serial clock falls; awake selects which track behaviour applies.
    task automatic do_frame(input int nf, input logic [11:0] smp, input bit awake, input bit exp_inv);
        logic [15:0] word = {4'b0000, smp};
        sample = smp;
        cs_n = 1'b0;
        tick(PH);
        chk("R2 oe at cs fall", 32'(oe), 1);
        chk("R3 first leading zero", 32'(sdata), 0);
        chk("R13 invalid at cs fall", 32'(inval), 32'(exp_inv));
        if (awake) chk("R2 hold at cs fall", 32'(track), 0);
        else chk("R12 hold before first edge", 32'(track), 0);
        for (int k = 1; k <= nf; k++) begin
            sclk = 1'b0;
            tick(PH);
            if (k < 16) begin
                chk("R3 oe mid frame", 32'(oe), 1);
                chk("R3 data bit", 32'(sdata), 32'(word[15-k]));
            end else begin
                chk("R4 oe off after 16th fall", 32'(oe), 0);
            end
            if (awake && k == 13) chk("R5 hold through 13th fall", 32'(track), 0);
            if (!awake && k == 1) chk("R12 track on first edge", 32'(track), 1);
            sclk = 1'b1;
            tick(PH);
            if (awake && k == 13) chk("R5 track after 13th fall", 32'(track), 1);
        end
        cs_n = 1'b1;
        tick(PH);
        chk("R6 oe off after cs rise", 32'(oe), 0);
    endtask

    task automatic t_reset();
        chk("R1 oe", 32'(oe), 0);
        chk("R1 powered", 32'(powered), 1);
        chk("R1 track", 32'(track), 1);
        chk("R1 invalid", 32'(inval), 0);
    endtask

    task automatic t_full_frames();
        do_frame(16, 12'hA5C, 1'b1, 1'b0);
        chk("R9 awake after 16", 32'(powered), 1);
        do_frame(16, 12'h3F1, 1'b1, 1'b0);
        do_frame(16, 12'hFFF, 1'b1, 1'b0);
        chk("R9 track after 16", 32'(track), 1);
    endtask

    task automatic t_glitch();
        do_frame(0, 12'h123, 1'b1, 1'b0);
        chk("R7 awake after 0", 32'(powered), 1);
        do_frame(1, 12'h456, 1'b1, 1'b0);
        chk("R7 awake after 1", 32'(powered), 1);
        chk("R7 track after 1", 32'(track), 1);
    endtask

    task automatic t_sleep_wake();
        do_frame(5, 12'h0F0, 1'b1, 1'b0);
        chk("R8 asleep after 5", 32'(powered), 0);
        chk("R8 hold asleep", 32'(track), 0);
        do_frame(6, 12'h555, 1'b0, 1'b1);
        chk("R10 still asleep after 6", 32'(powered), 0);
        chk("R10 hold asleep", 32'(track), 0);
        do_frame(12, 12'hAAA, 1'b0, 1'b1);
        chk("R11 awake after 12", 32'(powered), 1);
        do_frame(16, 12'h789, 1'b1, 1'b1);
        chk("R9 awake during timer", 32'(powered), 1);
        tick(PWRUP + 20);
        do_frame(10, 12'hC3C, 1'b1, 1'b0);
        chk("R9 awake after 10", 32'(powered), 1);
    endtask

    task automatic t_boundaries();
        do_frame(2, 12'h001, 1'b1, 1'b0);
        chk("R8 asleep after 2", 32'(powered), 0);
        do_frame(9, 12'h002, 1'b0, 1'b1);
        chk("R10 asleep after 9", 32'(powered), 0);
        do_frame(10, 12'h804, 1'b0, 1'b1);
        chk("R11 awake after 10", 32'(powered), 1);
        tick(PWRUP + 20);
        do_frame(9, 12'h008, 1'b1, 1'b0);
        chk("R8 asleep after 9", 32'(powered), 0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_full_frames();
        t_glitch();
        t_sleep_wake();
        t_boundaries();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule